// File: doc/BRIEF.md
# Line-Frequency Time-Base Divider

This block derives a slow time base from a 50 Hz or 60 Hz mains-derived clock. It divides the input clock by a fixed ratio pair, for example one pulse per second or one pulse per minute. One pin picks which ratio of the pair is used. The build parameter `VARIANT` picks the pair: 5/6, 50/60, 100/120, 300/360, 500/600 or 3000/3600.

The divider is a cascade of small counter stages, all clocked by the falling edge of the one input clock.

- The first stage is a six-state machine. It divides by 5 when `sel50_i` is high and by 6 when it is low. Its states are ST_ZERO (000), ST_ONE (001), ST_TWO (011), ST_THREE (111), ST_FOUR (110) and ST_FIVE (100).
  - In divide-by-6 mode the transitions run ZERO→ONE→TWO→THREE→FOUR→FIVE→ZERO. The wrap transition FIVE→ZERO raises the carry.
  - In divide-by-5 mode the transition FOUR→ZERO replaces FOUR→FIVE and raises the carry. ST_FIVE is left for ST_ZERO if it is ever found in this mode.
- Each later stage is a twisted-ring (Johnson) counter of 5 bits (÷10), 3 bits (÷6) or 1 bit (÷2). It steps only on a clock edge where the stage before it raises its carry.
- The output `div_o` is the output bit of the last stage.

An enable input freezes the whole chain. An asynchronous reset returns every stage to all zeros.

Top module: `line_divider_chain`

## Requirements
- R1: While `rst_i` is high, every stage is cleared to zero and `div_o` is 0.
- R2: With `sel50_i` high, `div_o` repeats with a period of the lower ratio of the variant's pair (5, 50, 100, 300, 500 or 3000 counted edges).
- R3: With `sel50_i` low, `div_o` repeats with a period of the higher ratio (6, 60, 120, 360, 600 or 3600 counted edges).
- R4: For every ratio except plain divide-by-5, `div_o` stays high for exactly half the ratio in counted edges. Counting from a cleared chain, it is low when (count mod ratio) < ratio/2 and high otherwise.
- R5: In the plain divide-by-5 mode, counting from a cleared chain, `div_o` is low for the first 2 of every 5 counted edges and high for the next 3.
- R6: A falling clock edge with `en_i` low does not advance any stage, so `div_o` holds its value.
- R7: After reset is released, the first rising edge of `div_o` comes after exactly ratio/2 counted edges, for every ratio except plain divide-by-5.
- R8: Counting takes place only on falling edges of `clk_i` with `en_i` high and `rst_i` low; a rising edge never changes the state.
- R9: A stage after the first changes state only on an edge where the preceding stage's carry is asserted, and then changes exactly one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Line-derived clock; stages advance on its falling edge |
| rst_i | input | 1 | Asynchronous active-high clear of the whole chain |
| en_i | input | 1 | Count enable; low freezes every stage |
| sel50_i | input | 1 | High: 50 Hz ratio (lower), low: 60 Hz ratio (higher) |
| div_o | output | 1 | Divided time-base output of the last stage |

## Verification
The assertions watch the following on every clock:

- the cleared output under reset;
- the frozen first stage and the held output while disabled;
- the carry-gated, single-bit stepping of each later stage.

Periods, duty cycle, the position of the first rising edge and the plain divide-by-5 shape are properties of whole counting sequences. Only the bench's scenarios can show these. It runs six variants side by side through both select settings, enable gaps and a mid-count reset, against a behavioural edge-counting model.

// File: rtl/line_div_pkg.sv
package line_div_pkg;

    typedef enum int {
        VAR_5_6,
        VAR_50_60,
        VAR_100_120,
        VAR_300_360,
        VAR_500_600,
        VAR_3000_3600
    } ratio_variant_e;

    localparam int MAX_STAGES = 4;

    // Number of stages in the cascade, including the 5/6 front stage.
    function automatic int stage_count(ratio_variant_e v);
        case (v)
            VAR_5_6:       return 1;
            VAR_50_60:     return 2;
            VAR_100_120:   return 3;
            VAR_300_360:   return 3;
            VAR_500_600:   return 3;
            VAR_3000_3600: return 4;
            default:       return 1;
        endcase
    endfunction

    // Register width of twisted-ring stage idx (idx >= 1); divides by 2*width.
    function automatic int stage_bits(ratio_variant_e v, int idx);
        if (idx == 1) return 5;
        case (v)
            VAR_100_120:   return 1;
            VAR_300_360:   return 3;
            VAR_500_600:   return 5;
            VAR_3000_3600: return (idx == 2) ? 3 : 5;
            default:       return 1;
        endcase
    endfunction

endpackage

// File: rtl/front_div56.sv
module front_div56 (
    input  logic clk_i,
    input  logic rst_i,
    input  logic adv_i,
    input  logic sel50_i,
    output logic tap_o,
    output logic carry_o
);

    typedef enum logic [2:0] {
        ST_ZERO  = 3'b000,
        ST_ONE   = 3'b001,
        ST_TWO   = 3'b011,
        ST_THREE = 3'b111,
        ST_FOUR  = 3'b110,
        ST_FIVE  = 3'b100
    } front_state_e;

    front_state_e state, state_nx;

    always_ff @(negedge clk_i or posedge rst_i) begin
        if (rst_i)      state <= ST_ZERO;
        else if (adv_i) state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_ZERO:  state_nx = ST_ONE;
            ST_ONE:   state_nx = ST_TWO;
            ST_TWO:   state_nx = ST_THREE;
            ST_THREE: state_nx = ST_FOUR;
            ST_FOUR:  state_nx = sel50_i ? ST_ZERO : ST_FIVE;
            ST_FIVE:  state_nx = ST_ZERO;
            default:  state_nx = ST_ZERO;
        endcase
    end

    // Output process: tap bit and wrap carry depend on the ratio in use.
    always_comb begin
        if (sel50_i) begin
            tap_o   = state[1];
            carry_o = adv_i && (state == ST_FOUR);
        end else begin
            tap_o   = state[2];
            carry_o = adv_i && (state == ST_FIVE);
        end
    end

    // R6: an edge without advance leaves the front stage untouched
    p_front_frozen_r6: assert property (@(negedge clk_i) disable iff (rst_i)
        !adv_i |=> $stable(state));

    // R5: in divide-by-5 mode the state after ST_FOUR is ST_ZERO
    p_div5_skip_r5: assert property (@(negedge clk_i) disable iff (rst_i)
        (adv_i && sel50_i && state == ST_FOUR) |=> (state == ST_ZERO));

endmodule

// File: rtl/johnson_stage.sv
module johnson_stage #(
    parameter int BITS = 5
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic adv_i,
    output logic tap_o,
    output logic carry_o
);

    localparam logic [BITS-1:0] LAST = {1'b1, {(BITS-1){1'b0}}};

    logic [BITS-1:0] ring_q, ring_nx;

    generate
        if (BITS == 1) begin : g_toggle
            assign ring_nx = ~ring_q;
        end else begin : g_ring
            assign ring_nx = {ring_q[BITS-2:0], ~ring_q[BITS-1]};
        end
    endgenerate

    always_ff @(negedge clk_i or posedge rst_i) begin
        if (rst_i)      ring_q <= '0;
        else if (adv_i) ring_q <= ring_nx;
    end

    assign tap_o   = ring_q[BITS-1];
    assign carry_o = adv_i && (ring_q == LAST);

    // R9: no carry from the previous stage, no change here
    p_stage_hold_r9: assert property (@(negedge clk_i) disable iff (rst_i)
        !adv_i |=> $stable(ring_q));

    // R9: each permitted step flips exactly one bit of the ring
    p_single_flip_r9: assert property (@(negedge clk_i) disable iff (rst_i)
        adv_i |=> ($countones(ring_q ^ $past(ring_q)) == 1));

endmodule

// File: rtl/line_divider_chain.sv
module line_divider_chain
    import line_div_pkg::*;
#(
    parameter ratio_variant_e VARIANT = VAR_3000_3600
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic sel50_i,
    output logic div_o
);

    localparam int NSTG = stage_count(VARIANT);

    logic [NSTG-1:0] tap;
    logic [NSTG-1:0] carry;

    front_div56 u_front (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .adv_i   (en_i),
        .sel50_i (sel50_i),
        .tap_o   (tap[0]),
        .carry_o (carry[0])
    );

    generate
        for (genvar k = 1; k < NSTG; k++) begin : g_stage
            johnson_stage #(
                .BITS (stage_bits(VARIANT, k))
            ) u_stage (
                .clk_i   (clk_i),
                .rst_i   (rst_i),
                .adv_i   (carry[k-1]),
                .tap_o   (tap[k]),
                .carry_o (carry[k])
            );
        end
    endgenerate

    assign div_o = tap[NSTG-1];

    // R1: reset holds the output low
    always @(negedge clk_i) begin
        if (rst_i) begin
            p_reset_low_r1: assert (div_o == 1'b0);
        end
    end

    // R6: disabled edges leave the output unchanged (select held)
    p_out_hold_r6: assert property (@(negedge clk_i) disable iff (rst_i)
        !en_i |=> ($stable(div_o) || (sel50_i != $past(sel50_i))));

endmodule

// File: tb/line_divider_chain_tb.sv
module line_divider_chain_tb;
    import line_div_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic ds  = 1'b1;
    logic [5:0] outs;

    int checks = 0;
    int errors = 0;
    int cnt    = 0;
    bit done   = 1'b0;

    int  rise_at [6];
    bit  tracking[6];
    bit  seen_first[6];
    logic prev_out[6];

    always #4 clk = ~clk;

    line_divider_chain #(.VARIANT(VAR_3000_3600)) u_dut (
        .clk_i(clk), .rst_i(rst), .en_i(en), .sel50_i(ds), .div_o(outs[5]));
    line_divider_chain #(.VARIANT(VAR_5_6)) u_dut_a (
        .clk_i(clk), .rst_i(rst), .en_i(en), .sel50_i(ds), .div_o(outs[0]));
    line_divider_chain #(.VARIANT(VAR_50_60)) u_dut_b (
        .clk_i(clk), .rst_i(rst), .en_i(en), .sel50_i(ds), .div_o(outs[1]));
    line_divider_chain #(.VARIANT(VAR_100_120)) u_dut_c (
        .clk_i(clk), .rst_i(rst), .en_i(en), .sel50_i(ds), .div_o(outs[2]));
    line_divider_chain #(.VARIANT(VAR_300_360)) u_dut_d (
        .clk_i(clk), .rst_i(rst), .en_i(en), .sel50_i(ds), .div_o(outs[3]));
    line_divider_chain #(.VARIANT(VAR_500_600)) u_dut_e (
        .clk_i(clk), .rst_i(rst), .en_i(en), .sel50_i(ds), .div_o(outs[4]));

    function automatic int ratio_of(int idx, logic sel);
        int base;
        case (idx)
            0: base = 5;
            1: base = 50;
            2: base = 100;
            3: base = 300;
            4: base = 500;
            default: base = 3000;
        endcase
        return sel ? base : (base / 5) * 6;
    endfunction

    function automatic logic model_out(int ratio, int c);
        if (ratio == 5) return ((c % 5) >= 2);
        return ((c % ratio) >= ratio / 2);
    endfunction

    task automatic check(string tag, int idx, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s dut%0d count=%0d actual=%b expected=%b", tag, idx, cnt, act, exp);
        end
    endtask

    task automatic check_int(string tag, int idx, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s dut%0d actual=%0d expected=%0d", tag, idx, act, exp);
        end
    endtask

    // Reference model: counts qualified falling edges (R8)
    always @(negedge clk) begin
        if (rst)     cnt <= 0;
        else if (en) cnt <= cnt + 1;
    end

    // Compare every cycle, between input drive (+1) and the next falling edge (+4)
    always @(posedge clk) begin
        #3;
        for (int i = 0; i < 6; i++) begin
            int r;
            string tag;
            r = ratio_of(i, ds);
            if (rst)           tag = "R1";
            else if (!en)      tag = "R6";
            else if (r == 5)   tag = "R5";
            else if (ds)       tag = "R2";
            else               tag = "R3";
            if (rst) begin
                check(tag, i, outs[i], 1'b0);
                seen_first[i] = 1'b0;
                tracking[i]   = 1'b0;
            end else begin
                check({tag, "/R8"}, i, outs[i], model_out(r, cnt));
                if (r != 5 && prev_out[i] === 1'b0 && outs[i] === 1'b1) begin
                    if (!seen_first[i]) begin
                        check_int("R7", i, cnt, r / 2);
                        seen_first[i] = 1'b1;
                    end
                    rise_at[i]  = cnt;
                    tracking[i] = 1'b1;
                end
                if (r != 5 && prev_out[i] === 1'b1 && outs[i] === 1'b0 && tracking[i]) begin
                    check_int("R4", i, cnt - rise_at[i], r / 2);
                end
            end
            prev_out[i] = outs[i];
        end
    end

    task automatic run(int n, bit e);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            en = e;
        end
    endtask

    task automatic do_reset(logic sel);
        @(posedge clk);
        #1;
        rst = 1'b1;
        en  = 1'b0;
        ds  = sel;
        run(3, 1'b0);
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 6; i++) prev_out[i] = 1'b0;
        do_reset(1'b1);
        run(1600, 1'b1);
        for (int k = 0; k < 200; k++) run(1, (k % 3) != 0);
        run(1600, 1'b1);
        do_reset(1'b0);
        run(1900, 1'b1);
        run(40, 1'b0);
        run(1900, 1'b1);
        run(37, 1'b1);
        do_reset(1'b1);
        run(60, 1'b1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at count=%0d", cnt);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule